// File: doc/BRIEF.md
# CAN controller operating-mode sequencer

This block holds the operating mode of a CAN controller and moves it between operation, reset, halt and sleep according to a 16-bit control word written by the CPU. A 2-bit request field selects operation, reset, halt or forced reset. A separate bit asks for sleep. Software learns that a reset request or a return to operation has completed by polling a status flag that is high only while the controller sits in reset. A forced reset acts at once. An ordinary reset or halt request waits for the bus to go idle.

The controller can also fall into halt by itself when the protocol engine signals bus-off entry, if the recovery field selects that behaviour. Bit-timing settings (prescaler, both time segments and jump width) are written as one packed word. That word is only accepted while the controller is in reset. The block hands the fields to the protocol engine as real counts, one more than the stored value. The three configuration bits for message-loss policy, identifier format and FIFO mailbox use are passed through unchanged.

Top module: `can_mode_seq`

## Requirements
- R1: After hardware reset the mode output is sleep (code 3), the reset flag is 0, the three configuration outputs are 0, the timing word reads 0 and every decoded timing count reads 1. The stored control word then has the sleep bit set and the request field at reset.
- R2: Mode codes are 0 operation, 1 reset, 2 halt, 3 sleep. Control bits 9:8 request 00 operation, 01 reset, 10 halt, 11 forced reset. Request 00 from reset or halt gives operation on the next clock, whatever the bus state.
- R3: Request 11 gives reset on the next clock from operation or halt, even with the bus busy. The reset flag is 1 exactly while the mode is reset.
- R4: Requests 01 and 10 take effect only on a clock where bus_idle_i is high. Until then the mode holds.
- R5: Control bit 10 requests sleep. It is accepted only from reset or halt and takes effect on the next clock. In operation it has no effect, and the request field is served instead.
- R6: While asleep, a control word with bit 10 clear returns the mode on the next clock to the mode held just before sleep. The request field is then served from the following clock.
- R7: When control bits 12:11 are 01 and the mode is operation, a busoff_i pulse gives halt on the next clock. The stored request becomes halt, so the mode stays in halt. With any other value in bits 12:11, busoff_i has no effect.
- R8: A timing write is stored only when the mode before the clock edge is reset. Otherwise it is ignored, including on the edge that enters reset.
- R9: The timing word holds TSEG1-1 in bits 23:20, prescaler-1 in bits 17:8, SJW-1 in bits 5:4 and TSEG2-1 in bits 2:0. The other bits read 0. Each decoded output equals its field plus one.
- R10: Control bit 3 drives ovr_mode_o, bits 2:1 drive id_fmt_o (2 means mixed identifiers) and bit 0 drives fifo_mode_o, from the clock after the write.
- R11: A control write and a qualifying bus-off pulse in the same cycle give halt. The written request field is replaced by halt, and the remaining written bits are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 16 | Control word value |
| bt_we_i | input | 1 | Timing word write strobe |
| bt_wdata_i | input | 32 | Packed timing word value |
| bus_idle_i | input | 1 | Bus is idle this cycle |
| busoff_i | input | 1 | One-cycle bus-off entry pulse |
| mode_o | output | 2 | Current mode code |
| rst_st_o | output | 1 | High while in reset mode |
| ovr_mode_o | output | 1 | Message-loss policy bit |
| id_fmt_o | output | 2 | Identifier format field |
| fifo_mode_o | output | 1 | FIFO mailbox mode bit |
| bt_word_o | output | 32 | Stored packed timing word |
| tseg1_o | output | 5 | Time segment 1 count |
| brp_o | output | 11 | Prescaler count |
| sjw_o | output | 3 | Jump width count |
| tseg2_o | output | 4 | Time segment 2 count |

## Verification
A CPU control write and a bus-off entry pulse can land on the same clock. The block must then choose between the written request and its automatic halt. The bench provokes this directly with a forced-reset write carrying the halt-at-bus-off setting alongside a pulse. It also provokes it at random with frequent pulses and writes. A bench reference model decides that halt wins and that the stored request becomes halt, and it judges the mode on that clock and on the clocks after it. A second collision, a timing write on the very edge that enters reset, is judged by the timing word staying unchanged.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

  localparam int CTRL_W   = 16;
  localparam int FIFO_BIT = 0;
  localparam int IDF_LSB  = 1;
  localparam int IDF_W    = 2;
  localparam int OVR_BIT  = 3;
  localparam int REQ_LSB  = 8;
  localparam int REQ_W    = 2;
  localparam int SLP_BIT  = 10;
  localparam int BOM_LSB  = 11;
  localparam int BOM_W    = 2;

  localparam logic [BOM_W-1:0]  BOM_HALT_AT_OFF = 2'b01;
  localparam logic [CTRL_W-1:0] CTRL_RST_VAL    = 16'h0500;

  localparam int BT_W    = 32;
  localparam int TS1_LSB = 20;
  localparam int TS1_W   = 4;
  localparam int BRP_LSB = 8;
  localparam int BRP_W   = 10;
  localparam int SJW_LSB = 4;
  localparam int SJW_W   = 2;
  localparam int TS2_LSB = 0;
  localparam int TS2_W   = 3;
  localparam int BT_NF   = 4;

  localparam int BT_FLD_LSB [BT_NF] = '{TS2_LSB, SJW_LSB, BRP_LSB, TS1_LSB};
  localparam int BT_FLD_W   [BT_NF] = '{TS2_W, SJW_W, BRP_W, TS1_W};

  typedef enum logic [1:0] {
    MD_OPER  = 2'd0,
    MD_RESET = 2'd1,
    MD_HALT  = 2'd2,
    MD_SLEEP = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    RQ_OPER  = 2'd0,
    RQ_RESET = 2'd1,
    RQ_HALT  = 2'd2,
    RQ_FORCE = 2'd3
  } req_e;

  function automatic req_e ctrl_req(input logic [CTRL_W-1:0] c);
    return req_e'(c[REQ_LSB +: REQ_W]);
  endfunction

  function automatic logic ctrl_sleep(input logic [CTRL_W-1:0] c);
    return c[SLP_BIT];
  endfunction

  function automatic logic [BOM_W-1:0] ctrl_bom(input logic [CTRL_W-1:0] c);
    return c[BOM_LSB +: BOM_W];
  endfunction

  function automatic logic [CTRL_W-1:0] ctrl_with_req(input logic [CTRL_W-1:0] c,
                                                      input req_e r);
    logic [CTRL_W-1:0] t;
    t = c;
    t[REQ_LSB +: REQ_W] = r;
    return t;
  endfunction

  function automatic mode_e req_target(input req_e r);
    case (r)
      RQ_OPER: return MD_OPER;
      RQ_HALT: return MD_HALT;
      default: return MD_RESET;
    endcase
  endfunction

  function automatic logic req_ready(input req_e r, input logic idle);
    return ((r == RQ_RESET) || (r == RQ_HALT)) ? idle : 1'b1;
  endfunction

  function automatic logic [BT_W-1:0] bt_keep_mask();
    logic [BT_W-1:0] m;
    m = '0;
    for (int f = 0; f < BT_NF; f++) begin
      for (int b = 0; b < BT_FLD_W[f]; b++) begin
        m[BT_FLD_LSB[f] + b] = 1'b1;
      end
    end
    return m;
  endfunction

  function automatic logic [TS1_W:0] bt_tseg1(input logic [BT_W-1:0] w);
    return {1'b0, w[TS1_LSB +: TS1_W]} + (TS1_W+1)'(1);
  endfunction

  function automatic logic [BRP_W:0] bt_brp(input logic [BT_W-1:0] w);
    return {1'b0, w[BRP_LSB +: BRP_W]} + (BRP_W+1)'(1);
  endfunction

  function automatic logic [SJW_W:0] bt_sjw(input logic [BT_W-1:0] w);
    return {1'b0, w[SJW_LSB +: SJW_W]} + (SJW_W+1)'(1);
  endfunction

  function automatic logic [TS2_W:0] bt_tseg2(input logic [BT_W-1:0] w);
    return {1'b0, w[TS2_LSB +: TS2_W]} + (TS2_W+1)'(1);
  endfunction

endpackage

// File: rtl/can_ctrl_reg.sv
module can_ctrl_reg
  import can_mode_pkg::*;
#(
  parameter int                W       = CTRL_W,
  parameter logic [CTRL_W-1:0] RST_VAL = CTRL_RST_VAL
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic          halt_take_i,
  output logic [W-1:0]  ctrl_eff_o,
  output logic [W-1:0]  ctrl_q_o
);

  logic [W-1:0] ctrl_q;

  // The word the sequencer acts on this cycle: a write is seen at once.
  assign ctrl_eff_o = wr_en_i ? wr_data_i : ctrl_q;
  assign ctrl_q_o   = ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= RST_VAL;
    end else if (halt_take_i) begin
      // Automatic halt overrides the request field of whatever is written.
      ctrl_q <= ctrl_with_req(ctrl_eff_o, RQ_HALT);
    end else if (wr_en_i) begin
      ctrl_q <= wr_data_i;
    end
  end

endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
  import can_mode_pkg::*;
#(
  parameter int W = CTRL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  ctrl_eff_i,
  input  logic          bus_idle_i,
  input  logic          busoff_i,
  output mode_e         mode_o,
  output logic          ev_boff_halt_o,
  output logic          ev_sleep_in_o,
  output logic          ev_wake_o,
  output logic          ev_req_move_o
);

  mode_e mode_q, mode_d;
  mode_e saved_q, saved_d;
  req_e  req;
  logic  slp;
  logic  unused_ctrl;

  assign req         = ctrl_req(ctrl_eff_i);
  assign slp         = ctrl_sleep(ctrl_eff_i);
  assign unused_ctrl = ^ctrl_eff_i;

  assign ev_boff_halt_o = (mode_q == MD_OPER) && busoff_i &&
                          (ctrl_bom(ctrl_eff_i) == BOM_HALT_AT_OFF);
  assign ev_wake_o      = (mode_q == MD_SLEEP) && !slp;
  assign ev_sleep_in_o  = slp && ((mode_q == MD_RESET) || (mode_q == MD_HALT));
  assign ev_req_move_o  = (mode_q != MD_SLEEP) && !ev_boff_halt_o && !ev_sleep_in_o &&
                          req_ready(req, bus_idle_i) && (req_target(req) != mode_q);

  always_comb begin
    mode_d  = mode_q;
    saved_d = saved_q;
    if (ev_boff_halt_o) begin
      mode_d = MD_HALT;
    end else if (ev_wake_o) begin
      mode_d = saved_q;
    end else if (ev_sleep_in_o) begin
      mode_d  = MD_SLEEP;
      saved_d = mode_q;
    end else if (ev_req_move_o) begin
      mode_d = req_target(req);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MD_SLEEP;
      saved_q <= MD_RESET;
    end else begin
      mode_q  <= mode_d;
      saved_q <= saved_d;
    end
  end

  assign mode_o = mode_q;

endmodule

// File: rtl/can_bt_reg.sv
module can_bt_reg
  import can_mode_pkg::*;
#(
  parameter int BW = BT_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic [BW-1:0]  wr_data_i,
  input  logic           unlock_i,
  output logic [BW-1:0]  bt_q_o
);

  localparam logic [BW-1:0] KEEP = bt_keep_mask();

  logic [BW-1:0] bt_q;
  logic          take;

  assign take = wr_en_i && unlock_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bt_q <= '0;
    end else if (take) begin
      bt_q <= wr_data_i & KEEP;
    end
  end

  assign bt_q_o = bt_q;

endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
  import can_mode_pkg::*;
#(
  parameter int CW = CTRL_W,
  parameter int BW = BT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CW-1:0]     ctrl_wdata_i,
  input  logic              bt_we_i,
  input  logic [BW-1:0]     bt_wdata_i,
  input  logic              bus_idle_i,
  input  logic              busoff_i,
  output logic [1:0]        mode_o,
  output logic              rst_st_o,
  output logic              ovr_mode_o,
  output logic [IDF_W-1:0]  id_fmt_o,
  output logic              fifo_mode_o,
  output logic [BW-1:0]     bt_word_o,
  output logic [TS1_W:0]    tseg1_o,
  output logic [BRP_W:0]    brp_o,
  output logic [SJW_W:0]    sjw_o,
  output logic [TS2_W:0]    tseg2_o
);

  logic [CW-1:0] ctrl_eff;
  logic [CW-1:0] ctrl_q;
  mode_e         mode;
  logic          ev_boff_halt, ev_sleep_in, ev_wake, ev_req_move;
  logic          unused_ctrl_q;

  can_ctrl_reg #(.W(CW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (ctrl_we_i),
    .wr_data_i   (ctrl_wdata_i),
    .halt_take_i (ev_boff_halt),
    .ctrl_eff_o  (ctrl_eff),
    .ctrl_q_o    (ctrl_q)
  );

  can_mode_fsm #(.W(CW)) u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .ctrl_eff_i     (ctrl_eff),
    .bus_idle_i     (bus_idle_i),
    .busoff_i       (busoff_i),
    .mode_o         (mode),
    .ev_boff_halt_o (ev_boff_halt),
    .ev_sleep_in_o  (ev_sleep_in),
    .ev_wake_o      (ev_wake),
    .ev_req_move_o  (ev_req_move)
  );

  can_bt_reg #(.BW(BW)) u_bt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (bt_we_i),
    .wr_data_i (bt_wdata_i),
    .unlock_i  (mode == MD_RESET),
    .bt_q_o    (bt_word_o)
  );

  assign mode_o        = mode;
  assign rst_st_o      = (mode == MD_RESET);
  assign ovr_mode_o    = ctrl_q[OVR_BIT];
  assign id_fmt_o      = ctrl_q[IDF_LSB +: IDF_W];
  assign fifo_mode_o   = ctrl_q[FIFO_BIT];
  assign unused_ctrl_q = ^ctrl_q;

  assign tseg1_o = bt_tseg1(bt_word_o);
  assign brp_o   = bt_brp(bt_word_o);
  assign sjw_o   = bt_sjw(bt_word_o);
  assign tseg2_o = bt_tseg2(bt_word_o);

endmodule

// File: rtl/can_mode_chk.sv
module can_mode_chk
  import can_mode_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        mode_o,
  input logic              busoff_i,
  input logic              bus_idle_i,
  input logic [CTRL_W-1:0] ctrl_eff,
  input logic [BT_W-1:0]   bt_word_o,
  input logic              ev_boff_halt,
  input logic              ev_sleep_in,
  input logic              ev_wake,
  input logic              ev_req_move
);

  logic [1:0] c_req;
  logic       c_slp;
  logic       c_boff_arm;
  logic       unused_eff;

  assign c_req      = ctrl_eff[REQ_LSB +: REQ_W];
  assign c_slp      = ctrl_eff[SLP_BIT];
  assign c_boff_arm = (ctrl_eff[BOM_LSB +: BOM_W] == 2'b01);
  assign unused_eff = ^ctrl_eff;

  AST_BUSOFF_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd0 && busoff_i && c_boff_arm) |=> (mode_o == 2'd2)) else $error("bus-off halt"); // R7

  AST_FORCE_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != 2'd3 && c_req == 2'b11 && !(mode_o == 2'd0 && busoff_i && c_boff_arm)
     && !(c_slp && mode_o != 2'd0)) |=> (mode_o == 2'd1)) else $error("forced reset"); // R3

  AST_WAIT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd0 && !bus_idle_i && c_req == 2'b01 && !busoff_i) |=> (mode_o == 2'd0))
    else $error("reset before idle"); // R4

  AST_NO_SLEEP_FROM_OPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd0) |=> (mode_o != 2'd3)) else $error("sleep from operation"); // R5

  AST_WAKE_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd3 && !c_slp) |=> (mode_o == 2'd1 || mode_o == 2'd2)) else $error("wake target"); // R6

  AST_BT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != 2'd1) |=> $stable(bt_word_o)) else $error("timing changed outside reset"); // R8

  AST_ONE_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ev_boff_halt, ev_sleep_in, ev_wake, ev_req_move})) else $error("event overlap"); // R11

endmodule

bind can_mode_seq can_mode_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_o       (mode_o),
  .busoff_i     (busoff_i),
  .bus_idle_i   (bus_idle_i),
  .ctrl_eff     (ctrl_eff),
  .bt_word_o    (bt_word_o),
  .ev_boff_halt (ev_boff_halt),
  .ev_sleep_in  (ev_sleep_in),
  .ev_wake      (ev_wake),
  .ev_req_move  (ev_req_move)
);

// File: tb/tb_can_mode_seq.sv
module tb_can_mode_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [15:0] ctrl_wd = '0;
  logic        bt_we = 1'b0;
  logic [31:0] bt_wd = '0;
  logic        idle = 1'b1;
  logic        boff = 1'b0;
  logic [1:0]  mode;
  logic        rst_st, ovr, fifo;
  logic [1:0]  idf;
  logic [31:0] btw;
  logic [4:0]  ts1;
  logic [10:0] brp;
  logic [2:0]  sjw;
  logic [3:0]  ts2;

  always #2.5ns clk = ~clk;

  can_mode_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wd),
    .bt_we_i(bt_we), .bt_wdata_i(bt_wd), .bus_idle_i(idle), .busoff_i(boff),
    .mode_o(mode), .rst_st_o(rst_st), .ovr_mode_o(ovr), .id_fmt_o(idf),
    .fifo_mode_o(fifo), .bt_word_o(btw), .tseg1_o(ts1), .brp_o(brp),
    .sjw_o(sjw), .tseg2_o(ts2)
  );

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;
  bit          done = 1'b0;

  // reference model state
  int          m_mode;
  int          m_saved;
  logic [15:0] m_ctrl;
  logic [31:0] m_bt;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int plus1(input logic [31:0] w, input int lsb, input int wid);
    return int'((w >> lsb) & ((32'd1 << wid) - 32'd1)) + 1;
  endfunction

  task automatic model_step(input bit we, input logic [15:0] wd, input bit bwe,
                            input logic [31:0] bwd, input bit id, input bit bo);
    logic [15:0] eff;
    int          rq;
    int          old;
    eff = we ? wd : m_ctrl;
    rq  = int'(eff[9:8]);
    old = m_mode;
    if (m_mode == 0 && bo && eff[12:11] == 2'b01) begin
      m_mode = 2;
      m_ctrl = {eff[15:10], 2'b10, eff[7:0]};
    end else begin
      m_ctrl = eff;
      if (m_mode == 3) begin
        if (!eff[10]) m_mode = m_saved;
      end else if (eff[10] && (m_mode == 1 || m_mode == 2)) begin
        m_saved = m_mode;
        m_mode  = 3;
      end else begin
        case (rq)
          3: m_mode = 1;
          1: if (id) m_mode = 1;
          2: if (id) m_mode = 2;
          default: m_mode = 0;
        endcase
      end
    end
    if (bwe && old == 1) m_bt = bwd & 32'h00F3_FF37;
  endtask

  task automatic compare_all();
    chk("R2 mode vs model", int'(mode), m_mode);
    chk("R3 reset flag vs model", int'(rst_st), (m_mode == 1) ? 1 : 0);
    chk("R10 config bits vs model", int'({ovr, idf, fifo}), int'(m_ctrl[3:0]));
    chk("R9 timing word vs model", int'(btw), int'(m_bt));
    chk("R9 decoded counts vs model", int'({ts1, brp, sjw, ts2}),
        (plus1(m_bt, 20, 4) << 18) | (plus1(m_bt, 8, 10) << 7) |
        (plus1(m_bt, 4, 2) << 4) | plus1(m_bt, 0, 3));
  endtask

  task automatic step(input bit we, input logic [15:0] wd, input bit bwe,
                      input logic [31:0] bwd, input bit id, input bit bo);
    ctrl_we = we; ctrl_wd = wd; bt_we = bwe; bt_wd = bwd; idle = id; boff = bo;
    @(posedge clk);
    model_step(we, wd, bwe, bwd, id, bo);
    @(negedge clk);
    ctrl_we = 1'b0; bt_we = 1'b0; boff = 1'b0;
    compare_all();
  endtask

  task automatic wr(input logic [15:0] wd, input bit id);
    step(1'b1, wd, 1'b0, 32'h0, id, 1'b0);
  endtask

  task automatic hold(input bit id);
    step(1'b0, 16'h0, 1'b0, 32'h0, id, 1'b0);
  endtask

  initial begin
    #750us;
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    m_mode = 3; m_saved = 1; m_ctrl = 16'h0500; m_bt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mode after reset", int'(mode), 3);
    chk("R1 reset flag after reset", int'(rst_st), 0);
    chk("R1 config after reset", int'({ovr, idf, fifo}), 0);
    chk("R1 timing word after reset", int'(btw), 0);
    chk("R1 counts after reset", int'({ts1, brp, sjw, ts2}), (1 << 18) | (1 << 7) | (1 << 4) | 1);
    compare_all();

    wr(16'h0100, 1'b1);
    chk("R6 wake to held reset", int'(mode), 1);
    chk("R3 flag in reset", int'(rst_st), 1);

    step(1'b0, 16'h0, 1'b1, 32'hFFFF_FFFF, 1'b1, 1'b0);
    chk("R9 all-ones word masked", int'(btw), 32'h00F3_FF37);
    chk("R9 max counts", int'({ts1, brp, sjw, ts2}), (16 << 18) | (1024 << 7) | (4 << 4) | 8);
    step(1'b0, 16'h0, 1'b1, 32'h0052_3A21, 1'b1, 1'b0);
    chk("R9 tseg1", int'(ts1), 6);
    chk("R9 prescaler", int'(brp), 571);
    chk("R9 sjw", int'(sjw), 3);
    chk("R9 tseg2", int'(ts2), 2);

    wr(16'h000D, 1'b0);
    chk("R2 operation with busy bus", int'(mode), 0);
    chk("R10 overrun/format/fifo", int'({ovr, idf, fifo}), 4'hD);

    step(1'b0, 16'h0, 1'b1, 32'h00F0_0000, 1'b1, 1'b0);
    chk("R8 timing write in operation ignored", int'(btw), 32'h0052_3A21);

    wr(16'h010D, 1'b0);
    chk("R4 reset waits for idle", int'(mode), 0);
    hold(1'b0);
    chk("R4 still waiting", int'(mode), 0);
    hold(1'b1);
    chk("R4 reset once idle", int'(mode), 1);

    wr(16'h000D, 1'b0);
    step(1'b1, 16'h030D, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0);
    chk("R3 forced reset next clock", int'(mode), 1);
    chk("R8 write on entry edge ignored", int'(btw), 32'h0052_3A21);

    wr(16'h050D, 1'b1);
    chk("R5 sleep from reset", int'(mode), 3);
    wr(16'h000D, 1'b1);
    chk("R6 wake returns to reset", int'(mode), 1);
    hold(1'b1);
    chk("R2 then operation", int'(mode), 0);

    wr(16'h040D, 1'b1);
    chk("R5 sleep ignored in operation", int'(mode), 0);

    wr(16'h020D, 1'b1);
    chk("R4 halt when idle", int'(mode), 2);
    wr(16'h060D, 1'b1);
    chk("R5 sleep from halt", int'(mode), 3);
    wr(16'h020D, 1'b1);
    chk("R6 wake returns to halt", int'(mode), 2);

    wr(16'h000D, 1'b1);
    step(1'b0, 16'h0, 1'b0, 32'h0, 1'b1, 1'b1);
    chk("R7 bus-off ignored without recovery mode", int'(mode), 0);
    wr(16'h080D, 1'b1);
    step(1'b0, 16'h0, 1'b0, 32'h0, 1'b1, 1'b1);
    chk("R7 bus-off enters halt", int'(mode), 2);
    hold(1'b1);
    chk("R7 halt persists", int'(mode), 2);

    wr(16'h080D, 1'b1);
    step(1'b1, 16'h0B0D, 1'b0, 32'h0, 1'b1, 1'b1);
    chk("R11 bus-off beats forced reset write", int'(mode), 2);
    hold(1'b1);
    chk("R11 written request replaced by halt", int'(mode), 2);
    chk("R11 other written bits kept", int'({ovr, idf, fifo}), 4'hD);

    seed = $urandom(32'h5EED_C0DE);
    for (int i = 0; i < 4000; i++) begin
      bit          we, bwe, id, bo;
      logic [15:0] wd;
      we  = ($urandom_range(3) == 0);
      bwe = ($urandom_range(3) == 0);
      id  = ($urandom_range(1) == 1);
      bo  = ($urandom_range(5) == 0);
      wd  = 16'h0;
      wd[12:11] = ($urandom_range(1) == 1) ? 2'b01 : 2'($urandom_range(3));
      wd[10]    = ($urandom_range(3) == 0);
      wd[9:8]   = 2'($urandom_range(3));
      wd[3:0]   = 4'($urandom_range(15));
      wd[15:13] = 3'($urandom_range(7));
      step(we, wd, bwe, $urandom, id, bo);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule